// File: doc/BRIEF.md
# Odd-Ratio Deserializer with Preset Word Alignment

This block turns several serial data lanes into parallel 7-bit words. The words are framed against a slow forwarded clock that runs alongside the data. That clock has an uneven duty cycle: it is high for four bit times and low for three. The block runs on a bit-rate clock and samples every lane, including the forwarded-clock lane, once per bit. It finds the rising transition of the forwarded clock and treats that bit as position 0 of a word. It checks that the clock keeps its 4-high/3-low shape before it reports lock. Each finished word is passed through a rotator before it is presented.

With an odd ratio and an uneven clock, the word boundary is fixed by the shape of the clock, so no training pattern is needed. The remaining offset is handled by a slip setting. Each receiver instance carries its own design-time preset, which is loaded at reset and on an align-reset input. Runtime align pulses step the slip by one. As an alternative mode, a startup sequencer issues a programmed number of slip pulses once a PLL-lock input rises. All lanes share the same clock lane and the same slip setting.

Top module: `odser_rx`

## Requirements
- R1: During and right after reset, word_out is all zeros, word_valid is 0 and frame_lock is 0. The slip setting is loaded with SLIP_PRESET.
- R2: A 0-then-1 transition between consecutive samples of fwd_clk_in marks position 0. The sample at position p (0..6) of a lane forms bit p of that lane's raw word, so position 0 is the LSB. The word is presented on word_out two clock edges after the position-6 bit is applied. word_valid is a one-cycle strobe, and word_out holds its value between updates.
- R3: frame_lock is set once three consecutive periods each show the clock-lane pattern 1,1,1,1,0,0,0 over positions 0..6. A period with any other pattern clears it, and so does a rising transition arriving before position 6 has been reached. word_valid is only set while frame_lock is set.
- R4: With slip value s (0..6), the output word is the raw word rotated right by s: out[i] = raw[(i+s) mod 7]. A slip of 0 places the boundary on the rising edge of the forwarded clock.
- R5: Asserting align_rst loads the slip setting with SLIP_PRESET and not with zero.
- R6: Each 0-to-1 transition of align_req advances the slip by exactly one, modulo 7, however long align_req stays high. A slip of 6 advances to 0.
- R7: After any slip change, or any align_rst cycle, the next word update is delivered with word_valid held at 0.
- R8: In startup mode, a rising edge of pll_lock starts START_PULSES single slip steps on alternate cycles, beginning one cycle after the edge. The default is ratio minus 2, which gives 5. A pll_lock that stays high, or that falls, adds no further steps. In preset mode, pll_lock has no effect.
- R9: Lane k occupies word_out[7k+6:7k]. All LANES lanes (4 by default, 28 bits in total) share the clock-lane framing and the slip value.
- R10: SLIP_PRESET, MODE and START_PULSES are separate parameters for each instance, so two receivers fed the same stream can present different rotations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_clk_in | input | 1 | Sampled forwarded-clock lane |
| lane_in | input | LANES | Serial data lanes, one bit per clock |
| align_rst | input | 1 | Reload the slip setting with SLIP_PRESET |
| align_req | input | 1 | Runtime slip request; acts on its rising edge |
| pll_lock | input | 1 | Lock indication that starts the slip pulse train (startup mode) |
| word_out | output | LANES*7 | Parallel words, lane k in bits 7k+6..7k |
| word_valid | output | 1 | One-cycle strobe for each good word |
| frame_lock | output | 1 | The clock-lane shape has been confirmed |

## Verification
A wrong slip count shows up at the next word update as a rotation of every lane by the wrong amount. Two instances with different presets and modes are fed the same stream, so a slip that is lost or doubled differs from the reference within one period. A position tracker that is off by one corrupts the next word. It also breaks the shape check within that period, which drops frame_lock about ten cycles after the bad bit. A strobe on the period just after a slip, or a missing one, is caught in the cycle it appears, because word_valid is compared on every clock.

// File: rtl/odser_pkg.sv
package odser_pkg;

  typedef enum logic [0:0] {
    SLIP_FROM_PRESET  = 1'b0,
    SLIP_FROM_STARTUP = 1'b1
  } slip_mode_e;

  // Expected forwarded-clock samples over one period: position p is high when p < high_bits
  function automatic logic [31:0] shape_mask(input int ratio, input int high_bits);
    logic [31:0] m;
    m = '0;
    for (int p = 0; p < 32; p++) begin
      if (p < ratio && p < high_bits) m[p] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/odser_phase.sv
module odser_phase #(
  parameter int RATIO        = 7,
  parameter int HIGH_BITS    = 4,
  parameter int LOCK_PERIODS = 3,
  localparam int POS_W       = $clog2(RATIO),
  localparam int CNT_W       = $clog2(LOCK_PERIODS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_clk,
  output logic [POS_W-1:0] cur_pos,
  output logic             word_end,
  output logic             lock_next,
  output logic             frame_lock
);

  localparam logic [POS_W-1:0] LAST   = POS_W'(RATIO - 1);
  localparam logic [RATIO-1:0] SHAPE  = RATIO'(odser_pkg::shape_mask(RATIO, HIGH_BITS));
  localparam logic [CNT_W-1:0] CNT_MX = CNT_W'(LOCK_PERIODS);

  logic             clk_d;
  logic [POS_W-1:0] pos_q;
  logic [RATIO-2:0] shape_q;
  logic [CNT_W-1:0] cnt_q, cnt_next;
  logic             rise, at_last, shape_ok;

  always_comb begin
    rise     = s_clk & ~clk_d;
    at_last  = (pos_q == LAST);
    cur_pos  = (rise || at_last) ? '0 : pos_q + 1'b1;
    word_end = (cur_pos == LAST);
    shape_ok = ({s_clk, shape_q} == SHAPE);
    cnt_next = cnt_q;
    if (rise && !at_last) begin
      cnt_next = '0;
    end else if (word_end) begin
      if (!shape_ok)            cnt_next = '0;
      else if (cnt_q != CNT_MX) cnt_next = cnt_q + 1'b1;
    end
    lock_next = (cnt_next == CNT_MX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_d      <= 1'b0;
      pos_q      <= LAST;
      shape_q    <= '0;
      cnt_q      <= '0;
      frame_lock <= 1'b0;
    end else begin
      clk_d      <= s_clk;
      pos_q      <= cur_pos;
      cnt_q      <= cnt_next;
      frame_lock <= lock_next;
      for (int i = 0; i < RATIO - 1; i++) begin
        if (cur_pos == POS_W'(i)) shape_q[i] <= s_clk;
      end
    end
  end

endmodule

// File: rtl/odser_lane.sv
module odser_lane #(
  parameter int RATIO  = 7,
  localparam int POS_W = $clog2(RATIO)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             d_in,
  input  logic [POS_W-1:0] cur_pos,
  input  logic             word_end,
  input  logic [POS_W-1:0] slip,
  output logic [RATIO-1:0] word
);

  logic             s_bit;
  logic [RATIO-2:0] raw_q;
  logic [RATIO-1:0] full, rot;

  always_comb begin
    full = {s_bit, raw_q};
    for (int i = 0; i < RATIO; i++) begin
      int idx;
      idx = i + int'(slip);
      if (idx >= RATIO) idx = idx - RATIO;
      rot[i] = full[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_bit <= 1'b0;
      raw_q <= '0;
      word  <= '0;
    end else begin
      s_bit <= d_in;
      for (int i = 0; i < RATIO - 1; i++) begin
        if (cur_pos == POS_W'(i)) raw_q[i] <= s_bit;
      end
      if (word_end) word <= rot;
    end
  end

endmodule

// File: rtl/odser_slip.sv
module odser_slip #(
  parameter int RATIO                   = 7,
  parameter int SLIP_PRESET             = 5,
  parameter odser_pkg::slip_mode_e MODE = odser_pkg::SLIP_FROM_PRESET,
  parameter int START_PULSES            = RATIO - 2,
  localparam int POS_W                  = $clog2(RATIO),
  localparam int PW                     = $clog2(START_PULSES + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             align_rst,
  input  logic             align_req,
  input  logic             pll_lock,
  input  logic             word_end,
  output logic [POS_W-1:0] slip_q,
  output logic             hold_q
);

  localparam logic [POS_W-1:0] PRESET_V = POS_W'(SLIP_PRESET % RATIO);
  localparam logic [POS_W-1:0] LAST     = POS_W'(RATIO - 1);
  localparam logic             SEQ_ON   = (MODE == odser_pkg::SLIP_FROM_STARTUP);

  logic          req_d, lock_d, gap_q;
  logic [PW-1:0] rem_q;
  logic          req_edge, seq_pulse, step;

  always_comb begin
    req_edge  = align_req & ~req_d;
    seq_pulse = SEQ_ON & (rem_q != '0) & ~gap_q;
    step      = req_edge | seq_pulse;
  end

  // Startup pulse train: one step, one idle cycle, repeated START_PULSES times
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_d <= 1'b0;
      rem_q  <= '0;
      gap_q  <= 1'b0;
    end else begin
      lock_d <= pll_lock;
      if (SEQ_ON && pll_lock && !lock_d) begin
        rem_q <= PW'(START_PULSES);
        gap_q <= 1'b0;
      end else if (rem_q != '0) begin
        if (!gap_q) begin
          rem_q <= rem_q - 1'b1;
          gap_q <= 1'b1;
        end else begin
          gap_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d  <= 1'b0;
      slip_q <= PRESET_V;
      hold_q <= 1'b0;
    end else begin
      req_d <= align_req;
      if (align_rst) begin
        slip_q <= PRESET_V;
        hold_q <= 1'b1;
      end else if (step) begin
        slip_q <= (slip_q == LAST) ? '0 : slip_q + 1'b1;
        hold_q <= 1'b1;
      end else if (word_end) begin
        hold_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/odser_rx.sv
module odser_rx #(
  parameter int LANES                   = 4,
  parameter int RATIO                   = 7,
  parameter int HIGH_BITS               = 4,
  parameter int LOCK_PERIODS            = 3,
  parameter int SLIP_PRESET             = 5,
  parameter odser_pkg::slip_mode_e MODE = odser_pkg::SLIP_FROM_PRESET,
  parameter int START_PULSES            = RATIO - 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fwd_clk_in,
  input  logic [LANES-1:0]       lane_in,
  input  logic                   align_rst,
  input  logic                   align_req,
  input  logic                   pll_lock,
  output logic [LANES*RATIO-1:0] word_out,
  output logic                   word_valid,
  output logic                   frame_lock
);

  localparam int POS_W = $clog2(RATIO);

  logic             s_clk;
  logic [POS_W-1:0] cur_pos;
  logic             word_end, lock_next;
  logic [POS_W-1:0] slip_q;
  logic             hold_q;

  always_ff @(posedge clk) begin
    if (rst) s_clk <= 1'b0;
    else     s_clk <= fwd_clk_in;
  end

  odser_phase #(
    .RATIO(RATIO), .HIGH_BITS(HIGH_BITS), .LOCK_PERIODS(LOCK_PERIODS)
  ) u_phase (
    .clk(clk), .rst(rst), .s_clk(s_clk), .cur_pos(cur_pos),
    .word_end(word_end), .lock_next(lock_next), .frame_lock(frame_lock)
  );

  odser_slip #(
    .RATIO(RATIO), .SLIP_PRESET(SLIP_PRESET), .MODE(MODE), .START_PULSES(START_PULSES)
  ) u_slip (
    .clk(clk), .rst(rst), .align_rst(align_rst), .align_req(align_req),
    .pll_lock(pll_lock), .word_end(word_end), .slip_q(slip_q), .hold_q(hold_q)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    odser_lane #(.RATIO(RATIO)) u_lane (
      .clk(clk), .rst(rst), .d_in(lane_in[k]), .cur_pos(cur_pos),
      .word_end(word_end), .slip(slip_q), .word(word_out[k*RATIO +: RATIO])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) word_valid <= 1'b0;
    else     word_valid <= word_end & lock_next & ~hold_q;
  end

endmodule

// File: rtl/odser_rx_chk.sv
module odser_rx_chk #(
  parameter int RATIO       = 7,
  parameter int WORD_W      = 28,
  parameter int SLIP_PRESET = 5,
  localparam int POS_W      = $clog2(RATIO)
) (
  input logic              clk,
  input logic              rst,
  input logic              word_valid,
  input logic              frame_lock,
  input logic              word_end,
  input logic              align_rst,
  input logic              hold_q,
  input logic [POS_W-1:0]  slip_q,
  input logic [WORD_W-1:0] word_out
);

  localparam logic [POS_W-1:0] PRESET_V = POS_W'(SLIP_PRESET % RATIO);
  localparam logic [POS_W-1:0] LAST     = POS_W'(RATIO - 1);

  assert_valid_locked_R3: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> frame_lock);

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  assert_word_steady_R2: assert property (@(posedge clk) disable iff (rst)
    !word_end |=> $stable(word_out));

  assert_slip_range_R4: assert property (@(posedge clk) disable iff (rst)
    slip_q <= LAST);

  assert_preset_load_R5: assert property (@(posedge clk) disable iff (rst)
    align_rst |=> (slip_q == PRESET_V));

  assert_single_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(align_rst) && (slip_q != $past(slip_q))) |->
      (slip_q == (($past(slip_q) == LAST) ? '0 : $past(slip_q) + 1'b1)));

  assert_blank_after_slip_R7: assert property (@(posedge clk) disable iff (rst)
    (hold_q && word_end) |=> !word_valid);

endmodule

bind odser_rx odser_rx_chk #(
  .RATIO(RATIO), .WORD_W(LANES*RATIO), .SLIP_PRESET(SLIP_PRESET)
) u_chk (
  .clk(clk), .rst(rst), .word_valid(word_valid), .frame_lock(frame_lock),
  .word_end(word_end), .align_rst(align_rst), .hold_q(hold_q),
  .slip_q(slip_q), .word_out(word_out)
);

// File: tb/odser_rx_tb.sv
module odser_rx_tb;
  localparam int LN = 4;
  localparam int RT = 7;
  localparam int WW = LN * RT;

  logic clk = 1'b0, rst = 1'b1, fclk = 1'b0;
  logic [LN-1:0] din = '0;
  logic arst = 1'b0, areq = 1'b0, plk = 1'b0;
  logic [WW-1:0] wo0, wo1;
  logic v0, v1, l0, l1;

  always #10 clk = ~clk;

  odser_rx #(.SLIP_PRESET(6), .MODE(odser_pkg::SLIP_FROM_PRESET)) u_dut (
    .clk(clk), .rst(rst), .fwd_clk_in(fclk), .lane_in(din), .align_rst(arst),
    .align_req(areq), .pll_lock(plk), .word_out(wo0), .word_valid(v0), .frame_lock(l0));

  odser_rx #(.SLIP_PRESET(0), .MODE(odser_pkg::SLIP_FROM_STARTUP)) u_dut_b (
    .clk(clk), .rst(rst), .fwd_clk_in(fclk), .lane_in(din), .align_rst(arst),
    .align_req(areq), .pll_lock(plk), .word_out(wo1), .word_valid(v1), .frame_lock(l1));

  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [RT-1:0] rotr(input logic [RT-1:0] w, input int s);
    logic [RT-1:0] r;
    for (int i = 0; i < RT; i++) r[i] = w[(i + s) % RT];
    return r;
  endfunction

  // behavioural reference, one entry per instance
  int  pre[2] = '{6, 0};
  bit  seq[2] = '{1'b0, 1'b1};
  int  m_pos[2], m_cnt[2], m_slip[2], m_rem[2];
  bit  m_prev[2], m_hold[2], m_reqd[2], m_plld[2], m_gap[2], m_valid[2], m_lock[2];
  bit  m_shape[2][RT];
  bit  m_raw[2][LN][RT];
  logic [WW-1:0] m_word[2];
  bit  st_clk;
  logic [LN-1:0] st_dat;

  task automatic model_step(input int d);
    bit rise, good, emit, step;
    int cur, cn;
    if (rst) begin
      m_pos[d] = RT - 1; m_cnt[d] = 0; m_slip[d] = pre[d]; m_rem[d] = 0;
      m_prev[d] = 0; m_hold[d] = 0; m_reqd[d] = 0; m_plld[d] = 0; m_gap[d] = 0;
      m_valid[d] = 0; m_lock[d] = 0; m_word[d] = '0;
      for (int i = 0; i < RT; i++) m_shape[d][i] = 0;
      return;
    end
    rise = st_clk && !m_prev[d];
    cur  = (rise || m_pos[d] == RT - 1) ? 0 : m_pos[d] + 1;
    m_shape[d][cur] = st_clk;
    for (int k = 0; k < LN; k++) m_raw[d][k][cur] = st_dat[k];
    cn = m_cnt[d];
    emit = (cur == RT - 1);
    if (rise && m_pos[d] != RT - 1) cn = 0;
    else if (emit) begin
      good = 1;
      for (int i = 0; i < RT; i++) if (m_shape[d][i] != (i < 4)) good = 0;
      cn = good ? ((cn < 3) ? cn + 1 : 3) : 0;
    end
    m_valid[d] = emit && (cn == 3) && !m_hold[d];
    if (emit) begin
      for (int k = 0; k < LN; k++) begin
        logic [RT-1:0] rw;
        for (int i = 0; i < RT; i++) rw[i] = m_raw[d][k][i];
        m_word[d][k*RT +: RT] = rotr(rw, m_slip[d]);
      end
    end
    m_lock[d] = (cn == 3);
    m_cnt[d] = cn; m_pos[d] = cur; m_prev[d] = st_clk;
    step = (areq && !m_reqd[d]) || (seq[d] && m_rem[d] > 0 && !m_gap[d]);
    if (seq[d] && plk && !m_plld[d]) begin m_rem[d] = 5; m_gap[d] = 0; end
    else if (m_rem[d] > 0) begin
      if (!m_gap[d]) begin m_rem[d]--; m_gap[d] = 1; end else m_gap[d] = 0;
    end
    if (arst) begin m_slip[d] = pre[d]; m_hold[d] = 1; end
    else if (step) begin m_slip[d] = (m_slip[d] + 1) % RT; m_hold[d] = 1; end
    else if (emit) m_hold[d] = 0;
    m_reqd[d] = areq; m_plld[d] = plk;
  endtask

  logic [WW-1:0] last0 = '0, last1 = '0;
  int strobes0 = 0;

  always @(posedge clk) begin
    #5;
    if (!done) begin
      model_step(0);
      model_step(1);
      st_clk = rst ? 1'b0 : fclk;
      st_dat = rst ? '0 : din;
      check(wo0 == m_word[0], "R2 R4 R9 word_out u_dut", 64'(wo0), 64'(m_word[0]));
      check(wo1 == m_word[1], "R4 R8 R10 word_out u_dut_b", 64'(wo1), 64'(m_word[1]));
      check(v0 == m_valid[0], "R3 R7 word_valid u_dut", 64'(v0), 64'(m_valid[0]));
      check(v1 == m_valid[1], "R3 R7 word_valid u_dut_b", 64'(v1), 64'(m_valid[1]));
      check(l0 == m_lock[0] && l1 == m_lock[1], "R3 frame_lock", {l0, l1}, {m_lock[0], m_lock[1]});
      if (v0) begin last0 = wo0; strobes0++; end
      if (v1) last1 = wo1;
    end
  end

  logic [RT-1:0] W [LN] = '{7'h13, 7'h2C, 7'h45, 7'h5A};

  function automatic logic [WW-1:0] expect_rot(input int s);
    logic [WW-1:0] r;
    for (int k = 0; k < LN; k++) r[k*RT +: RT] = rotr(W[k], s);
    return r;
  endfunction

  task automatic send(input int n, input int high);
    for (int p = 0; p < n; p++) begin
      for (int i = 0; i < RT; i++) begin
        @(negedge clk);
        fclk = (i < high);
        for (int k = 0; k < LN; k++) din[k] = W[k][i];
      end
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int s_before;
    repeat (3) @(negedge clk);
    check(wo0 == '0 && !v0 && !l0 && !l1, "R1 reset state", {wo0, v0, l0}, '0);
    rst = 1'b0;
    plk = 1'b1;                                    // R8: startup train in u_dut_b only
    send(5, 4);
    check(l0 && l1, "R3 lock after good periods", {l0, l1}, 2'b11);
    check(last0 == expect_rot(6), "R4 R10 R9 preset 6 rotation", 64'(last0), 64'(expect_rot(6)));
    check(last1 == expect_rot(5), "R8 R10 five startup steps", 64'(last1), 64'(expect_rot(5)));

    areq = 1'b1;                                   // R6: held request, one step only
    s_before = strobes0;
    send(1, 4);
    check(strobes0 == s_before, "R7 strobe blanked after slip", 64'(strobes0), 64'(s_before));
    send(2, 4);
    areq = 1'b0;
    send(3, 4);
    check(last0 == expect_rot(0), "R6 wrap 6 to 0 single step", 64'(last0), 64'(expect_rot(0)));
    check(last1 == expect_rot(6), "R6 single step u_dut_b", 64'(last1), 64'(expect_rot(6)));

    send(1, 5);                                    // R3: wrong clock shape
    send(1, 4);
    check(!l0 && !l1, "R3 lock lost on bad shape", {l0, l1}, 2'b00);
    send(3, 4);
    check(l0 && l1, "R3 relock", {l0, l1}, 2'b11);

    arst = 1'b1;                                   // R5
    send(1, 4);
    arst = 1'b0;
    send(4, 4);
    check(last0 == expect_rot(6), "R5 align_rst loads preset 6", 64'(last0), 64'(expect_rot(6)));
    check(last1 == expect_rot(0), "R5 align_rst loads preset 0", 64'(last1), 64'(expect_rot(0)));

    plk = 1'b0;                                    // R8: second rising edge
    send(1, 4);
    plk = 1'b1;
    send(4, 4);
    check(last1 == expect_rot(5), "R8 second pll_lock edge", 64'(last1), 64'(expect_rot(5)));
    check(last0 == expect_rot(6), "R8 preset mode ignores pll_lock", 64'(last0), 64'(expect_rot(6)));

    for (int p = 0; p < 8; p++) begin
      for (int k = 0; k < LN; k++) W[k] = RT'($urandom);
      send(1, 4);
    end
    send(2, 4);
    check(last0 == expect_rot(6), "R9 R4 random words u_dut", 64'(last0), 64'(expect_rot(6)));
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule